// File: doc/BRIEF.md
# Execute-Stage Integer ALU with Immediate Expansion

This block is the arithmetic and logic unit of the execute stage of a small 32-bit RISC core. Each cycle it receives an already decoded 3-bit operation, operand A, either a register operand B or a 16-bit constant, and a flag-write enable. It returns the result in the same cycle. The four condition flags (zero, negative, overflow, carry) are held in a register and written on the next clock edge.

When the constant is used, it becomes a 32-bit operand. For most operations a half-select input places it in the upper or lower half of the word and fills the other half with zeros. AND fills the other half with ones instead. Shifts sign-extend the constant. The shift amount is a signed number: positive values shift left and negative values shift right. The same half-select input chooses between logical and arithmetic shift. The special opcode can also carry out a two-way select driven by a condition bit. The carry-using operations read the registered carry flag as their carry input.

Top module: `xalu_core`

## Requirements
- R1: Operation codes on `op_i`: 000 add, 001 add with carry, 010 subtract (a + ~b + 1), 011 subtract with borrow (a + ~b + C, where C is the registered carry flag), 100 and, 101 or, 110 xor, 111 special. With `use_imm_i`=0, operand B is `opb_i`.
- R2: With `use_imm_i`=1 and `op_i` other than 111, `half_i`=1 puts `imm_i` in bits 31:16 of operand B, and `half_i`=0 puts it in bits 15:0. The other half is 0x0000.
- R3: For AND (100) with `use_imm_i`=1, the unused half of operand B is 0xFFFF.
- R4: For shifts (`op_i`=111, `sel_i`=0), the amount is operand B read as a signed number. With `use_imm_i`=1 it is `imm_i` sign-extended. An amount from 0 to 31 shifts A left by that many places. An amount from -1 to -31 shifts A right by its magnitude.
- R5: For shifts, `half_i`=0 selects a logical right shift (zero fill) and `half_i`=1 an arithmetic right shift (sign fill).
- R6: A shift amount outside -31..31 gives a result of 0.
- R7: `flags_o` is {Z,N,V,C} in bits 3..0. When flags are written, Z = (result == 0) and N = result bit 31.
- R8: V is set only for the four arithmetic operations. It is set when the sign bits of A and of the effective addend (B, or ~B for the subtracts) are equal and the result sign differs from them. All other operations write V = 0.
- R9: For arithmetic operations, C is the carry out of bit 31 of the addition.
- R10: For a left shift by k (1..31), C is A bit 32-k, the lowest bit shifted out. A shift by 0, right shifts, out-of-range shifts, logic operations and select all write C = 0.
- R11: The flags are written on the clock edge only when `flag_en_i`=1. Otherwise they keep their value.
- R12: With `op_i`=111 and `sel_i`=1, the result is `opa_i` when `cond_i`=1 and `opb_i` otherwise.
- R13: `rst_n` low at a clock edge clears `flags_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| op_i | input | 3 | Operation code |
| use_imm_i | input | 1 | 1: operand B comes from `imm_i` |
| half_i | input | 1 | Constant half select; shift kind for shifts |
| sel_i | input | 1 | With op 111: select instead of shift |
| cond_i | input | 1 | Select condition |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Register operand B |
| imm_i | input | 16 | 16-bit constant |
| flag_en_i | input | 1 | Write flags at the next edge |
| result_o | output | 32 | Combinational result |
| flags_o | output | 4 | Registered {Z,N,V,C} |

## Verification
The carry input of add-with-carry and subtract-with-borrow is read from the same flag register that the previous operation has just written. In one cycle the block therefore both consumes the old carry and produces the new one. The bench provokes this with back-to-back carry-using operations that have flag writing enabled. Some of these follow an operation whose flag write was disabled, so the old carry must still be in place. A cycle-accurate model carries its own flag state from one vector to the next and judges the combinational result before the edge and the flags after it.

// File: rtl/xalu_pkg.sv
// Package: shared operation codes and flag bit positions for the ALU.
// Assumes a 3-bit opcode and a 4-bit flag word {Z,N,V,C}.
package xalu_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_ADDC = 3'b001,
        OP_SUB  = 3'b010,
        OP_SUBB = 3'b011,
        OP_AND  = 3'b100,
        OP_OR   = 3'b101,
        OP_XOR  = 3'b110,
        OP_SPEC = 3'b111
    } alu_op_e;

    localparam int FLG_Z = 3;
    localparam int FLG_N = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;
endpackage

// File: rtl/xalu_opnd.sv
// Operand B former: picks the register operand, or widens the constant.
// Shifts sign-extend it; otherwise the constant goes to the selected half,
// and the other half is filled with ones for AND and zeros for the rest.
// Assumes W > IW.
module xalu_opnd #(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input  logic [2:0]    op_i,
    input  logic          use_imm_i,
    input  logic          half_i,
    input  logic [IW-1:0] imm_i,
    input  logic [W-1:0]  opb_i,
    output logic [W-1:0]  opnd_o
);
    import xalu_pkg::*;

    localparam int FW = W - IW;

    logic [FW-1:0] fill;

    // Fill value for the half not covered by the constant.
    always_comb begin
        fill = (op_i == OP_AND) ? {FW{1'b1}} : {FW{1'b0}};
    end

    // Operand B selection and constant widening.
    always_comb begin
        if (!use_imm_i) begin
            opnd_o = opb_i;
        end else if (op_i == OP_SPEC) begin
            opnd_o = {{FW{imm_i[IW-1]}}, imm_i};
        end else if (half_i) begin
            opnd_o = {imm_i, fill};
        end else begin
            opnd_o = {fill, imm_i};
        end
    end
endmodule

// File: rtl/xalu_arith.sv
// Adder for add, add-with-carry, subtract and subtract-with-borrow.
// sub_i inverts B; use_cin_i takes the carry input from flag_c_i,
// otherwise the carry input equals sub_i. Produces carry and overflow.
module xalu_arith #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         use_cin_i,
    input  logic         flag_c_i,
    output logic [W-1:0] sum_o,
    output logic         c_o,
    output logic         v_o
);
    logic [W-1:0] b_eff;
    logic         cin;
    logic [W:0]   wide;

    // Effective addend, carry input and full-width sum.
    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        cin   = use_cin_i ? flag_c_i : sub_i;
        wide  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        sum_o = wide[W-1:0];
        c_o   = wide[W];
        v_o   = (a_i[W-1] == b_eff[W-1]) && (wide[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/xalu_shift.sv
// Bidirectional shifter driven by a signed amount. 0..W-1 shifts left,
// -1..-(W-1) shifts right (logical or arithmetic); any other amount gives 0.
// Carry out is the lowest bit shifted out on a left shift, else 0.
module xalu_shift #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] amt_i,
    input  logic         arith_i,
    output logic [W-1:0] res_o,
    output logic         c_o
);
    localparam int SW = $clog2(W);
    localparam logic [W-1:0] MAXV = W - 1;

    logic         neg;
    logic [W-1:0] mag;
    logic         ok;
    logic [SW-1:0] k;
    logic [W:0]   lext;
    logic [W-1:0] rres;

    // Amount decode: direction, magnitude and range check.
    always_comb begin
        neg = amt_i[W-1];
        mag = neg ? (~amt_i + 1'b1) : amt_i;
        ok  = (mag <= MAXV);
        k   = mag[SW-1:0];
    end

    // Left path carries the last bit out into the extra top position.
    always_comb begin
        lext = {1'b0, a_i} << k;
        rres = arith_i ? $unsigned($signed(a_i) >>> k) : (a_i >> k);
    end

    // Output select by direction and range.
    always_comb begin
        if (!ok) begin
            res_o = '0;
            c_o   = 1'b0;
        end else if (neg) begin
            res_o = rres;
            c_o   = 1'b0;
        end else begin
            res_o = lext[W-1:0];
            c_o   = lext[W];
        end
    end
endmodule

// File: rtl/xalu_core.sv
// Execute-stage ALU top: forms operand B, computes the result in the same
// cycle and holds the {Z,N,V,C} flags, written on the edge when enabled.
// Assumes decoded inputs stable around the clock edge; reset is synchronous.
module xalu_core #(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_i,
    input  logic          use_imm_i,
    input  logic          half_i,
    input  logic          sel_i,
    input  logic          cond_i,
    input  logic [W-1:0]  opa_i,
    input  logic [W-1:0]  opb_i,
    input  logic [IW-1:0] imm_i,
    input  logic          flag_en_i,
    output logic [W-1:0]  result_o,
    output logic [3:0]    flags_o
);
    import xalu_pkg::*;

    logic [W-1:0] opnd_b;
    logic [W-1:0] sum;
    logic         sum_c;
    logic         sum_v;
    logic [W-1:0] sh_res;
    logic         sh_c;
    logic         is_arith;
    logic         is_shift;
    logic [3:0]   flags_d;

    xalu_opnd #(.W(W), .IW(IW)) u_opnd (
        .op_i      (op_i),
        .use_imm_i (use_imm_i),
        .half_i    (half_i),
        .imm_i     (imm_i),
        .opb_i     (opb_i),
        .opnd_o    (opnd_b)
    );

    xalu_arith #(.W(W)) u_arith (
        .a_i       (opa_i),
        .b_i       (opnd_b),
        .sub_i     (op_i[1]),
        .use_cin_i (op_i[0]),
        .flag_c_i  (flags_o[FLG_C]),
        .sum_o     (sum),
        .c_o       (sum_c),
        .v_o       (sum_v)
    );

    xalu_shift #(.W(W)) u_shift (
        .a_i     (opa_i),
        .amt_i   (opnd_b),
        .arith_i (half_i),
        .res_o   (sh_res),
        .c_o     (sh_c)
    );

    // Operation class decode.
    always_comb begin
        is_arith = (op_i[2] == 1'b0);
        is_shift = (op_i == OP_SPEC) && !sel_i;
    end

    // Result multiplexer.
    always_comb begin
        unique case (op_i)
            OP_AND:  result_o = opa_i & opnd_b;
            OP_OR:   result_o = opa_i | opnd_b;
            OP_XOR:  result_o = opa_i ^ opnd_b;
            OP_SPEC: result_o = sel_i ? (cond_i ? opa_i : opb_i) : sh_res;
            default: result_o = sum;
        endcase
    end

    // Next flag value from the current result and operation class.
    always_comb begin
        flags_d[FLG_Z] = (result_o == '0);
        flags_d[FLG_N] = result_o[W-1];
        flags_d[FLG_V] = is_arith && sum_v;
        flags_d[FLG_C] = is_arith ? sum_c : (is_shift && sh_c);
    end

    // Flag register with synchronous active-low reset and write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_o <= 4'b0000;
        end else if (flag_en_i) begin
            flags_o <= flags_d;
        end
    end
endmodule

// File: rtl/xalu_core_chk.sv
// Checker for xalu_core: port-level properties of the flag register and
// the select path. Attached to every xalu_core instance by bind.
module xalu_core_chk #(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    op_i,
    input logic          use_imm_i,
    input logic          sel_i,
    input logic          cond_i,
    input logic [W-1:0]  opa_i,
    input logic [W-1:0]  opb_i,
    input logic [IW-1:0] imm_i,
    input logic          flag_en_i,
    input logic [W-1:0]  result_o,
    input logic [3:0]    flags_o
);
    // R13: reset clears the flags
    a_r13_reset_clear: assert property (@(posedge clk)
        !rst_n |=> flags_o == 4'b0000);

    // R11: flags hold while writing is disabled
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_en_i |=> $stable(flags_o));

    // R7: zero and negative follow the result
    a_r7_zn: assert property (@(posedge clk) disable iff (!rst_n)
        flag_en_i |=> (flags_o[3] == ($past(result_o) == '0))
                   && (flags_o[2] == $past(result_o[W-1])));

    // R8: non-arithmetic operations clear overflow
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en_i && op_i[2]) |=> !flags_o[1]);

    // R10: right shift by a constant clears carry
    a_r10_right_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en_i && op_i == 3'b111 && !sel_i && use_imm_i && imm_i[IW-1])
        |=> !flags_o[0]);

    // R12: select picks operand A or register operand B
    always_comb begin
        if (rst_n && op_i == 3'b111 && sel_i) begin
            a_r12_select: assert (result_o == (cond_i ? opa_i : opb_i));
        end
    end
endmodule

bind xalu_core xalu_core_chk #(.W(W), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .use_imm_i (use_imm_i),
    .sel_i     (sel_i),
    .cond_i    (cond_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .imm_i     (imm_i),
    .flag_en_i (flag_en_i),
    .result_o  (result_o),
    .flags_o   (flags_o)
);

// File: tb/xalu_core_tb_top.sv
module xalu_core_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic        use_imm_i = 1'b0;
    logic        half_i = 1'b0;
    logic        sel_i = 1'b0;
    logic        cond_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [15:0] imm_i = '0;
    logic        flag_en_i = 1'b0;
    logic [31:0] result_o;
    logic [3:0]  flags_o;

    int tests = 0;
    int fails = 0;
    logic [3:0] mflags = 4'b0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    xalu_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .use_imm_i(use_imm_i),
        .half_i(half_i), .sel_i(sel_i), .cond_i(cond_i), .opa_i(opa_i),
        .opb_i(opb_i), .imm_i(imm_i), .flag_en_i(flag_en_i),
        .result_o(result_o), .flags_o(flags_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: computes result and next flags from the requirements.
    task automatic model(input logic [2:0] op, input logic ui, input logic hf,
                         input logic sl, input logic cd, input logic [31:0] a,
                         input logic [31:0] rb, input logic [15:0] im,
                         input logic cin, output logic [31:0] res, output logic [3:0] nf);
        logic [31:0] b;
        logic [31:0] bx;
        longint s;
        int amt;
        logic v;
        logic c;
        v = 1'b0; c = 1'b0; res = '0;
        if (!ui) b = rb;
        else if (op == 3'd7) b = {{16{im[15]}}, im};
        else begin
            logic [15:0] other;
            other = (op == 3'd4) ? 16'hFFFF : 16'h0000;
            b = hf ? {im, other} : {other, im};
        end
        if (op <= 3'd3) begin
            bx = (op >= 3'd2) ? ~b : b;
            s = longint'(a) + longint'(bx);
            if (op == 3'd0) s = s;
            else if (op == 3'd2) s = s + 1;
            else s = s + (cin ? 1 : 0);
            res = s[31:0];
            c = s[32];
            v = (a[31] == bx[31]) && (res[31] != a[31]);
        end else if (op == 3'd4) res = a & b;
        else if (op == 3'd5) res = a | b;
        else if (op == 3'd6) res = a ^ b;
        else if (sl) res = cd ? a : rb;
        else begin
            amt = $signed(b);
            if (amt >= 0 && amt <= 31) begin
                res = a;
                for (int i = 0; i < amt; i++) begin
                    c = res[31];
                    res = {res[30:0], 1'b0};
                end
            end else if (amt < 0 && amt >= -31) begin
                res = a;
                for (int i = 0; i < -amt; i++) res = {hf ? res[31] : 1'b0, res[31:1]};
            end else res = '0;
        end
        nf = {res == 32'd0, res[31], v, c};
    endtask

    // Applies one vector, checks the result before the edge and the flags after it.
    task automatic apply(input string tag, input logic [2:0] op, input logic ui,
                         input logic hf, input logic sl, input logic cd,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic fen);
        logic [31:0] er;
        logic [3:0] ef;
        @(negedge clk);
        op_i = op; use_imm_i = ui; half_i = hf; sel_i = sl; cond_i = cd;
        opa_i = a; opb_i = b; imm_i = im; flag_en_i = fen;
        model(op, ui, hf, sl, cd, a, b, im, mflags[0], er, ef);
        #1;
        check({tag, " result"}, result_o, er);
        @(posedge clk);
        #1;
        if (fen) mflags = ef;
        check({tag, " flags"}, {28'd0, flags_o}, {28'd0, mflags});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R13 reset flags", {28'd0, flags_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        apply("R1 R9 add wrap", 3'd0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'd1, 16'd0, 1);
        apply("R8 add overflow", 3'd0, 0, 0, 0, 0, 32'h7FFF_FFFF, 32'd1, 16'd0, 1);
        apply("R9 addc carry-in", 3'd1, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'd1, 16'd0, 1);
        apply("R9 addc chained", 3'd1, 0, 0, 0, 0, 32'd10, 32'd20, 16'd0, 1);
        apply("R1 R9 sub equal", 3'd2, 0, 0, 0, 0, 32'd5, 32'd5, 16'd0, 1);
        apply("R11 hold", 3'd2, 0, 0, 0, 0, 32'd3, 32'd5, 16'd0, 0);
        apply("R1 subb with C", 3'd3, 0, 0, 0, 0, 32'd9, 32'd4, 16'd0, 1);
        apply("R8 sub overflow", 3'd2, 0, 0, 0, 0, 32'h8000_0000, 32'd1, 16'd0, 1);
        apply("R2 imm low", 3'd5, 1, 0, 0, 0, 32'h0, 32'hDEAD_BEEF, 16'h1234, 1);
        apply("R2 imm high", 3'd6, 1, 1, 0, 0, 32'h0000_00FF, 32'h0, 16'hABCD, 1);
        apply("R3 and fill low", 3'd4, 1, 0, 0, 0, 32'hCAFE_F00D, 32'h0, 16'h0F0F, 1);
        apply("R3 and fill high", 3'd4, 1, 1, 0, 0, 32'hCAFE_F00D, 32'h0, 16'h0F0F, 1);
        apply("R2 add imm high", 3'd0, 1, 1, 0, 0, 32'd1, 32'h0, 16'h8000, 1);
        apply("R4 R10 left 1", 3'd7, 1, 0, 0, 0, 32'h8000_0001, 32'h0, 16'd1, 1);
        apply("R10 left 4 carry", 3'd7, 1, 0, 0, 0, 32'h1000_0000, 32'h0, 16'd4, 1);
        apply("R10 left 0", 3'd7, 1, 0, 0, 0, 32'h8000_0000, 32'h0, 16'd0, 1);
        apply("R4 R10 left 31", 3'd7, 0, 0, 0, 0, 32'h0000_0003, 32'd31, 16'd0, 1);
        apply("R5 right arith", 3'd7, 1, 1, 0, 0, 32'h8000_0000, 32'h0, 16'hFFFC, 1);
        apply("R5 right logical", 3'd7, 1, 0, 0, 0, 32'h8000_0000, 32'h0, 16'hFFFC, 1);
        apply("R4 right 31 reg", 3'd7, 0, 1, 0, 0, 32'h8000_0000, 32'hFFFF_FFE1, 16'd0, 1);
        apply("R6 amount 32", 3'd7, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'd32, 16'd0, 1);
        apply("R6 amount -32", 3'd7, 1, 1, 0, 0, 32'hFFFF_FFFF, 32'h0, 16'hFFE0, 1);
        apply("R12 select true", 3'd7, 0, 0, 1, 1, 32'h1111_1111, 32'h2222_2222, 16'd0, 1);
        apply("R12 select false", 3'd7, 0, 0, 1, 0, 32'h1111_1111, 32'h0000_0000, 16'd5, 1);
        apply("R1 R9 set C", 3'd0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'd0, 1);
        apply("R11 hold logic", 3'd6, 0, 0, 0, 0, 32'h1, 32'h1, 16'd0, 0);
        apply("R9 subb after hold", 3'd3, 0, 0, 0, 0, 32'd0, 32'd0, 16'd0, 1);

        for (int n = 0; n < 400; n++) begin
            logic [2:0] op;
            logic [15:0] im;
            logic [31:0] b;
            op = 3'($urandom);
            im = 16'($urandom);
            b = $urandom;
            if (op == 3'd7 && n[0]) begin
                im = 16'($signed(int'($urandom_range(0, 80)) - 40));
                b = 32'($signed(int'($urandom_range(0, 80)) - 40));
            end
            apply("R1 R7 random", op, 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), $urandom, b, im, 1'($urandom));
        end

        apply("R7 pre-reset", 3'd0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'd0, 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R13 reset mid-run", {28'd0, flags_o}, 32'd0);
        mflags = 4'b0000;
        @(negedge clk);
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule